// File: doc/BRIEF.md
# PCI configuration address translator

This block turns a processor access into the south-side configuration window into a type-0 PCI configuration address. A 32-bit working word is formed from the low half-word of the processor offset and the low half-word of a map-configuration value held elsewhere. The upper part of that word, bits [31:11], is a one-hot select field. Its lowest set bit gives the device number. The function and register fields are taken from the word as they stand. The bus number is supplied from outside.

Each request strobe produces a one-cycle result in the following cycle. There are three possible outcomes. An accepted access yields an enabled configuration address and a pulse that clears the bridge's received master-abort and received target-abort status bits. An erroneous access, with an empty select field or a misaligned halfword or word, raises an error pulse and issues no cycle. An access with the map value's type-1 bit set is not supported: it is dropped silently, and a read returns all ones at its width. The PCI data phase and the storage of the map value are handled by neighbouring logic.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The working word is {map_cfg_i[15:0], offset_i[15:0]}. The function field of the issued address is word[10:8]. The register field is word[7:2], placed in address bits [7:2].
- R2: The device number in address bits [15:11] is the index of the lowest set bit of word[31:11], counted from 0 at word bit 11. Higher set bits are ignored.
- R3: An issued address has bit 31 set, bits [30:24] zero, bus_i in [23:16] and bits [1:0] zero.
- R4: When map_cfg_i[16] is 1, the access issues no cycle and raises no error. A write is dropped. A read returns all ones at the access width on refuse_data_o (size_i 00 byte: 0x000000FF, 01 halfword: 0x0000FFFF, 10 or 11 word: 0xFFFFFFFF).
- R5: When map_cfg_i[16] is 0 and word[31:11] is all zeros, err_o pulses and valid_o stays low.
- R6: When map_cfg_i[16] is 0, a halfword access with offset_i[0]=1, or a word access with offset_i[1:0]≠0, pulses err_o and issues no cycle. A byte access may take any alignment.
- R7: abort_clr_o pulses together with valid_o for every accepted access, read or write, and at no other time.
- R8: valid_o, err_o and abort_clr_o are single-cycle pulses in the cycle after a clock edge that samples req_i high, and are low otherwise. cfg_addr_o holds the last accepted address until the next accepted access.
- R9: While rst_ni is low, every output is zero.
- R10: The type-1 check takes priority over the error checks. A type-1 access with an empty select field, or one that is misaligned, raises no error.
- R11: refuse_data_o is updated on each request. It is zero after an accepted access or any write. After a refused read, whether type-1 or erroneous, it is all ones at the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| offset_i | input | 16 | Low half-word of processor offset in the window |
| map_cfg_i | input | 32 | Map-configuration value; [15:0] upper select bits, [16] type-1 |
| bus_i | input | 8 | Bus number for the issued address |
| cfg_addr_o | output | 32 | Issued configuration address with enable in bit 31 |
| valid_o | output | 1 | Pulse: configuration cycle issued |
| err_o | output | 1 | Pulse: access refused as erroneous |
| abort_clr_o | output | 1 | Pulse: clear received master/target abort status |
| refuse_data_o | output | 32 | Read data for a refused read |

## Verification
The assertions assume that req_i, wr_i, size_i, offset_i, map_cfg_i and bus_i are stable across the edge that samples a request. They also assume that the map value does not change between a request and the check one cycle later. The stimulus keeps to this by changing every input on the falling edge and holding req_i high for exactly one rising edge per access. The bench uses no back-to-back requests, so each pulse can be tied to one access. Its size codes are limited to the four defined in R4.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int unsigned OFS_W      = 16;
  localparam int unsigned WORD_W     = 2 * OFS_W;
  localparam int unsigned MAP_W      = 32;
  localparam int unsigned TYPE1_BIT  = 16;
  localparam int unsigned SEL_LO     = 11;
  localparam int unsigned SEL_W      = WORD_W - SEL_LO;
  localparam int unsigned DEV_W      = 5;
  localparam int unsigned BUS_W      = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic accept;
    logic error;
    logic refuse_rd;
  } gate_res_t;
endpackage

// File: rtl/cfg_word_build.sv
module cfg_word_build
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned P_OFS_W  = OFS_W,
  parameter int unsigned P_MAP_W  = MAP_W,
  parameter int unsigned P_T1_BIT = TYPE1_BIT
) (
  input  logic [P_OFS_W-1:0]   offset_i,
  input  logic [P_MAP_W-1:0]   map_cfg_i,
  output logic [2*P_OFS_W-1:0] word_o,
  output logic                 type1_o
);
  localparam int unsigned HI_W = P_MAP_W - P_OFS_W - 1;

  assign word_o  = {map_cfg_i[P_OFS_W-1:0], offset_i};
  assign type1_o = map_cfg_i[P_T1_BIT];

  logic unused_hi;
  assign unused_hi = ^map_cfg_i[P_MAP_W-1 -: HI_W];
endmodule

// File: rtl/cfg_lsb_enc.sv
module cfg_lsb_enc #(
  parameter int unsigned IN_W  = 21,
  parameter int unsigned IDX_W = (IN_W > 1) ? $clog2(IN_W) : 1
) (
  input  logic [IN_W-1:0]  sel_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             none_o
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (sel_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign none_o = ~|sel_i;
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
  import cfg_xlate_pkg::*;
(
  input  acc_size_e  size_i,
  input  logic [1:0] ofs_lo_i,
  input  logic       wr_i,
  input  logic       type1_i,
  input  logic       sel_none_i,
  output gate_res_t  res_o,
  output logic [31:0] ones_o
);
  logic misalign;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin misalign = 1'b0;        ones_o = 32'h0000_00ff; end
      SZ_HALF: begin misalign = ofs_lo_i[0]; ones_o = 32'h0000_ffff; end
      default: begin misalign = |ofs_lo_i;   ones_o = 32'hffff_ffff; end
    endcase
  end

  // type-1 refusal outranks both error causes
  always_comb begin
    res_o.accept    = ~type1_i & ~sel_none_i & ~misalign;
    res_o.error     = ~type1_i & (sel_none_i | misalign);
    res_o.refuse_rd = ~wr_i & ~res_o.accept;
  end
endmodule

// File: rtl/cfg_resp_reg.sv
module cfg_resp_reg
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  gate_res_t         res_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       ones_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              err_o,
  output logic              clr_o,
  output logic [31:0]       rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      clr_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= req_i & res_i.accept;
      err_o   <= req_i & res_i.error;
      clr_o   <= req_i & res_i.accept;
      if (req_i) begin
        rdata_o <= res_i.refuse_rd ? ones_i : 32'h0;
        if (res_i.accept) addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [1:0]  size_i,
  input  logic [15:0] offset_i,
  input  logic [31:0] map_cfg_i,
  input  logic [7:0]  bus_i,
  output logic [31:0] cfg_addr_o,
  output logic        valid_o,
  output logic        err_o,
  output logic        abort_clr_o,
  output logic [31:0] refuse_data_o
);
  localparam int unsigned ENC_W = (SEL_W > 1) ? $clog2(SEL_W) : 1;
  localparam int unsigned PAD_W = WORD_W - 1 - BUS_W - 16;

  logic [WORD_W-1:0] word;
  logic              type1;
  logic [ENC_W-1:0]  dev_idx;
  logic              sel_none;
  gate_res_t         gate;
  logic [31:0]       ones;
  logic [WORD_W-1:0] addr_c;
  logic [DEV_W-1:0]  dev_num;

  cfg_word_build u_word (
    .offset_i  (offset_i),
    .map_cfg_i (map_cfg_i),
    .word_o    (word),
    .type1_o   (type1)
  );

  cfg_lsb_enc #(.IN_W(SEL_W), .IDX_W(ENC_W)) u_enc (
    .sel_i  (word[WORD_W-1:SEL_LO]),
    .idx_o  (dev_idx),
    .none_o (sel_none)
  );

  cfg_access_gate u_gate (
    .size_i     (acc_size_e'(size_i)),
    .ofs_lo_i   (offset_i[1:0]),
    .wr_i       (wr_i),
    .type1_i    (type1),
    .sel_none_i (sel_none),
    .res_o      (gate),
    .ones_o     (ones)
  );

  assign dev_num = DEV_W'(dev_idx);
  assign addr_c  = {1'b1, {PAD_W{1'b0}}, bus_i, dev_num, word[10:8], word[7:2], 2'b00};

  cfg_resp_reg #(.ADDR_W(WORD_W)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .res_i   (gate),
    .addr_i  (addr_c),
    .ones_i  (ones),
    .addr_o  (cfg_addr_o),
    .valid_o (valid_o),
    .err_o   (err_o),
    .clr_o   (abort_clr_o),
    .rdata_o (refuse_data_o)
  );
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk
  import cfg_xlate_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        wr_i,
  input logic [1:0]  size_i,
  input logic [15:0] offset_i,
  input logic [31:0] map_cfg_i,
  input logic [7:0]  bus_i,
  input logic [31:0] cfg_addr_o,
  input logic        valid_o,
  input logic        err_o,
  input logic        abort_clr_o,
  input logic [31:0] refuse_data_o
);
  logic unused_chk;
  assign unused_chk = ^{map_cfg_i[31:17], offset_i[10:2]};

  logic sel_empty;
  assign sel_empty = (map_cfg_i[15:0] == 16'h0) && (offset_i[15:11] == 5'h0);

  p_addr_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cfg_addr_o[31] && cfg_addr_o[30:24] == 7'h0 && cfg_addr_o[1:0] == 2'b00));

  p_bus_field_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cfg_addr_o[23:16] == $past(bus_i));

  p_type1_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && map_cfg_i[16]) |=> (!valid_o && !err_o && !abort_clr_o));

  p_sel_empty_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !map_cfg_i[16] && sel_empty) |=> (err_o && !valid_o));

  p_half_misalign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !map_cfg_i[16] && size_i == 2'b01 && offset_i[0]) |=> (err_o && !valid_o));

  p_clr_only_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_clr_o |-> valid_o);

  p_pulse_needs_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !err_o && !abort_clr_o));

  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(cfg_addr_o));

  p_write_no_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i) |=> refuse_data_o == 32'h0);
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk chk_i (.*);

// File: tb/cfg_addr_xlate_tb_top.sv
module cfg_addr_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  size_i = 2'b10;
  logic [15:0] offset_i = '0;
  logic [31:0] map_cfg_i = '0;
  logic [7:0]  bus_i = '0;
  logic [31:0] cfg_addr_o;
  logic        valid_o, err_o, abort_clr_o;
  logic [31:0] refuse_data_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfg_addr_xlate dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(logic [15:0] ofs, logic [31:0] map, logic [7:0] bus);
    logic [31:0] w;
    logic [4:0]  dev;
    w   = {map[15:0], ofs};
    dev = '0;
    for (int i = 20; i >= 0; i--) if (w[11+i]) dev = 5'(i);
    return {1'b1, 7'h0, bus, dev, w[10:8], w[7:2], 2'b00};
  endfunction

  function automatic logic [31:0] ones_for(logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0000_00ff;
      2'b01:   return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  // one request; results sampled on the falling edge after the capturing edge
  task automatic access(logic wr, logic [1:0] sz, logic [15:0] ofs, logic [31:0] map, logic [7:0] bus);
    @(negedge clk_i);
    wr_i = wr; size_i = sz; offset_i = ofs; map_cfg_i = map; bus_i = bus; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic expect_accept(string tag, logic wr, logic [1:0] sz, logic [15:0] ofs,
                               logic [31:0] map, logic [7:0] bus);
    access(wr, sz, ofs, map, bus);
    check({tag, " valid"}, 32'(valid_o), 32'd1);
    check({tag, " err"}, 32'(err_o), 32'd0);
    check({tag, " addr"}, cfg_addr_o, model_addr(ofs, map, bus));
    check({tag, " R7 abort_clr"}, 32'(abort_clr_o), 32'd1);
    check({tag, " R11 refuse data"}, refuse_data_o, 32'h0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9 addr", cfg_addr_o, 32'h0);
    check("R9 pulses", {29'h0, valid_o, err_o, abort_clr_o}, 32'h0);
    check("R9 refuse data", refuse_data_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_fields();
    expect_accept("R1 R2 dev0 rd", 1'b0, 2'b10, 16'h0f7c, 32'h0, 8'h00);
    expect_accept("R1 R3 bus", 1'b1, 2'b01, 16'h8536, 32'h0, 8'hA5);
    expect_accept("R2 map bit", 1'b0, 2'b00, 16'h0003, 32'h0000_0001, 8'h3C);
    expect_accept("R2 lowest of many", 1'b0, 2'b10, 16'hA000, 32'h0000_8001, 8'h01);
    expect_accept("R2 top bit", 1'b1, 2'b10, 16'h00fc, 32'h0000_8000, 8'hFF);
    check("R2 top bit dev", 32'(cfg_addr_o[15:11]), 32'd20);
    check("R3 enable", 32'(cfg_addr_o[31]), 32'd1);
  endtask

  task automatic t_type1();
    logic [31:0] held;
    held = cfg_addr_o;
    for (int s = 0; s < 4; s++) begin
      access(1'b0, 2'(s), 16'h0800, 32'h0001_0000, 8'h12);
      check("R4 rd valid", 32'(valid_o), 32'd0);
      check("R4 rd err", 32'(err_o), 32'd0);
      check("R4 rd ones", refuse_data_o, ones_for(2'(s)));
    end
    access(1'b1, 2'b10, 16'h0800, 32'h0001_0000, 8'h12);
    check("R4 wr dropped", {29'h0, valid_o, err_o, abort_clr_o}, 32'h0);
    check("R4 wr addr held", cfg_addr_o, held);
    check("R11 wr data", refuse_data_o, 32'h0);
  endtask

  task automatic t_sel_zero();
    logic [31:0] held;
    held = cfg_addr_o;
    access(1'b0, 2'b01, 16'h07fe, 32'hFFFE_0000, 8'h44);
    check("R5 err", 32'(err_o), 32'd1);
    check("R5 valid", 32'(valid_o), 32'd0);
    check("R7 no clr", 32'(abort_clr_o), 32'd0);
    check("R11 err read data", refuse_data_o, 32'h0000_ffff);
    check("R8 addr held", cfg_addr_o, held);
  endtask

  task automatic t_misalign();
    access(1'b1, 2'b01, 16'h0801, 32'h0, 8'h00);
    check("R6 half odd err", {30'h0, valid_o, err_o}, 32'h1);
    access(1'b0, 2'b10, 16'h0802, 32'h0, 8'h00);
    check("R6 word +2 err", {30'h0, valid_o, err_o}, 32'h1);
    check("R11 word err data", refuse_data_o, 32'hffff_ffff);
    access(1'b0, 2'b11, 16'h0801, 32'h0, 8'h00);
    check("R6 word +1 err", {30'h0, valid_o, err_o}, 32'h1);
    expect_accept("R6 byte odd ok", 1'b0, 2'b00, 16'h1003, 32'h0, 8'h07);
    expect_accept("R6 half even ok", 1'b1, 2'b01, 16'h1006, 32'h0, 8'h07);
  endtask

  task automatic t_priority();
    access(1'b0, 2'b10, 16'h0003, 32'h0001_0000, 8'h00);
    check("R10 type1 beats err", {30'h0, valid_o, err_o}, 32'h0);
    check("R10 ones", refuse_data_o, 32'hffff_ffff);
  endtask

  task automatic t_pulse();
    expect_accept("R8 setup", 1'b0, 2'b10, 16'h4010, 32'h0, 8'h22);
    @(negedge clk_i);
    check("R8 single pulse", {29'h0, valid_o, err_o, abort_clr_o}, 32'h0);
    check("R8 addr hold", cfg_addr_o, model_addr(16'h4010, 32'h0, 8'h22));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fields();
        t_type1();
        t_sel_zero();
        t_misalign();
        t_priority();
        t_pulse();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R8: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule